// File: doc/BRIEF.md
# External Bus Idle-Cycle Inserter

This block decides how many dead bus cycles to leave between two back-to-back external accesses. A device that is slow to stop driving the data bus, such as a read-only memory with a long turn-off time, could otherwise still be driving when the next device starts. The block watches each access request, that is its direction and its 3-bit area number, and compares it with the access that was last accepted. When the pair of accesses needs a gap, the block holds its ready output low for the required number of cycles and raises an idle indication. It then accepts the pending access.

Three kinds of transition need a gap: a read followed by a read to another area, a read followed by a write, and a write followed by a read. After a read, a per-area select bit picks one of two count settings, A or B. The bit that counts is the one for the area that was just accessed, not the one for the area about to be accessed. After a write, setting A always applies. A 12-bit control word is loaded through a write-enable port. Its layout is bits [7:0] per-area select (1 = setting B), bits [9:8] setting A and bits [11:10] setting B.

Top module: `bus_idle_gap`

## Requirements
- R1: The first access after reset is accepted in the cycle it is presented, with no idle cycles, because no earlier access is on record.
- R2: A read that follows a read to the same area gets no idle cycles. A read that follows a read to a different area gets the after-read count.
- R3: A write that follows a read gets the after-read count. That count is setting B when the select bit of the previous area is 1, and setting A otherwise.
- R4: A read that follows a write gets the setting A count, whatever the select bits hold.
- R5: A write that follows a write gets no idle cycles, whatever the areas.
- R6: Setting A codes map to cycles as 00→1, 01→2, 10→3, 11→4.
- R7: Setting B codes map to cycles as 00→1, 01→2, 10→4, 11→4.
- R8: The select bit consulted after a read is the bit indexed by the previously accessed area, never by the upcoming one.
- R9: After reset the control word is 0xF00, so every gap-producing transition gets four idle cycles.
- R10: During an inserted gap, ready is low and idle is high for exactly the gap count. In the following cycle ready is high and the access is accepted. The recorded history does not change during the gap.
- R11: A control word write made during a gap does not change that gap's length. It applies from the next evaluated transition.
- R12: No transition ever produces more than four idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req | input | 1 | Master presents an external access; held until accepted |
| acc_wr | input | 1 | Direction of the presented access, 1 = write |
| acc_area | input | 3 | Area number of the presented access |
| acc_rdy | output | 1 | Access is accepted on a clock edge where acc_req and acc_rdy are both high |
| idle_busy | output | 1 | An idle cycle is being inserted in this cycle |
| cfg_we | input | 1 | Load cfg_wdata into the control word |
| cfg_wdata | input | 12 | Control word: [11:10] setting B, [9:8] setting A, [7:0] per-area select |

## Verification
The hardest case to reach is a control word change that lands inside a gap already in progress. The write must come after the count has been loaded and before it runs out. The bench handles this by pulsing the write port from inside the access task, in the first stalled cycle. It then checks that the current gap keeps its old length and that the next transition uses the new one. A second delicate case is R8, where the previous and upcoming areas have different select bits. The bench orders the accesses so that the two possible readings of the select bit give different counts.

// File: rtl/bus_idle_pkg.sv
// Shared sizes, control-word layout and count decoding for the idle-cycle inserter.
// Assumes the area number is small enough that one select bit per area is practical.
package bus_idle_pkg;
    parameter int AREA_W  = 3;
    localparam int N_AREAS = 1 << AREA_W;
    localparam int CNT_W   = 3;
    localparam int CFG_W   = N_AREAS + 4;

    typedef struct packed {
        logic [1:0]         setb;
        logic [1:0]         seta;
        logic [N_AREAS-1:0] sel;
    } idle_cfg_t;

    localparam idle_cfg_t CFG_RESET = '{setb: 2'b11, seta: 2'b11, sel: '0};

    // Setting A: code plus one cycle.
    function automatic logic [CNT_W-1:0] seta_cycles(input logic [1:0] code);
        return CNT_W'(code) + CNT_W'(1);
    endfunction

    // Setting B: 1, 2, then 4 for both upper codes.
    function automatic logic [CNT_W-1:0] setb_cycles(input logic [1:0] code);
        return code[1] ? CNT_W'(4) : (code[0] ? CNT_W'(2) : CNT_W'(1));
    endfunction
endpackage

// File: rtl/idle_cfg_reg.sv
// Control word holding the two count settings and the per-area select bits.
// Assumes writes are single-cycle pulses; takes effect from the following cycle.
module idle_cfg_reg
    import bus_idle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output idle_cfg_t        cfg
);
    // Hold the control word; load on write, return to four-cycle defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg <= CFG_RESET;
        else if (we) cfg <= idle_cfg_t'(wdata);
    end
endmodule

// File: rtl/access_history.sv
// Records the direction and area of the last accepted access.
// Assumes 'accept' is high only on a cycle where the master's access is taken.
module access_history
    import bus_idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              wr,
    input  logic [AREA_W-1:0] area,
    output logic              valid,
    output logic              last_wr,
    output logic [AREA_W-1:0] last_area
);
    // Capture the accepted access; mark history empty after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid     <= 1'b0;
            last_wr   <= 1'b0;
            last_area <= '0;
        end else if (accept) begin
            valid     <= 1'b1;
            last_wr   <= wr;
            last_area <= area;
        end
    end

    assert_hist_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> valid);
endmodule

// File: rtl/gap_decider.sv
// Decides whether a transition needs idle cycles and how many.
// Purely combinational; assumes the history inputs describe the previously accepted access.
module gap_decider
    import bus_idle_pkg::*;
(
    input  idle_cfg_t         cfg,
    input  logic              hist_valid,
    input  logic              hist_wr,
    input  logic [AREA_W-1:0] hist_area,
    input  logic              req_wr,
    input  logic [AREA_W-1:0] req_area,
    output logic              need_gap,
    output logic [CNT_W-1:0]  gap_cycles
);
    logic [CNT_W-1:0] area_cyc [N_AREAS];
    logic             rd_rd_diff, rd_wr, wr_rd;

    // One after-read count per area, chosen by that area's select bit.
    for (genvar g = 0; g < N_AREAS; g++) begin : g_area_cnt
        assign area_cyc[g] = cfg.sel[g] ? setb_cycles(cfg.setb) : seta_cycles(cfg.seta);
    end

    // Classify the transition and pick the count from the previous area or setting A.
    always_comb begin
        rd_rd_diff = !hist_wr && !req_wr && (hist_area != req_area);
        rd_wr      = !hist_wr &&  req_wr;
        wr_rd      =  hist_wr && !req_wr;
        need_gap   = hist_valid && (rd_rd_diff || rd_wr || wr_rd);
        gap_cycles = wr_rd ? seta_cycles(cfg.seta) : area_cyc[hist_area];
    end
endmodule

// File: rtl/gap_counter.sv
// Counts down the idle cycles of one transition and then releases the pending access.
// Assumes the master holds its request stable until it is accepted.
module gap_counter
    import bus_idle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_gap,
    input  logic [CNT_W-1:0] load_cycles,
    input  logic             accept,
    output logic             idle_now,
    output logic             gate_open
);
    logic [CNT_W-1:0] cnt;
    logic             paid;
    logic             start;

    // Start a gap when one is needed, not yet served and no countdown is running.
    always_comb begin
        start     = req_gap && !paid && (cnt == '0);
        idle_now  = start || (cnt != '0);
        gate_open = !idle_now;
    end

    // Countdown of remaining idle cycles and the "gap served" marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            paid <= 1'b0;
        end else if (start) begin
            cnt  <= load_cycles - CNT_W'(1);
            paid <= (load_cycles == CNT_W'(1));
        end else if (cnt != '0) begin
            cnt  <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) paid <= 1'b1;
        end else if (accept) begin
            paid <= 1'b0;
        end
    end

    assert_idle_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(3));
    assert_load_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (load_cycles >= CNT_W'(1) && load_cycles <= CNT_W'(4)));
endmodule

// File: rtl/bus_idle_gap.sv
// Top of the external-bus idle-cycle inserter: stalls the master between accesses
// whose direction or area change could let two devices drive the data bus at once.
// Assumes acc_req, acc_wr and acc_area stay stable from presentation until accepted.
module bus_idle_gap
    import bus_idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_wr,
    input  logic [AREA_W-1:0] acc_area,
    output logic              acc_rdy,
    output logic              idle_busy,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata
);
    idle_cfg_t         cfg;
    logic              hist_valid, hist_wr;
    logic [AREA_W-1:0] hist_area;
    logic              need_gap;
    logic [CNT_W-1:0]  gap_cycles;
    logic              idle_now, gate_open;
    logic              accept;

    // Handshake outputs and the acceptance strobe.
    always_comb begin
        acc_rdy   = gate_open;
        idle_busy = idle_now;
        accept    = acc_req && gate_open;
    end

    idle_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    access_history u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .wr        (acc_wr),
        .area      (acc_area),
        .valid     (hist_valid),
        .last_wr   (hist_wr),
        .last_area (hist_area)
    );

    gap_decider u_dec (
        .cfg        (cfg),
        .hist_valid (hist_valid),
        .hist_wr    (hist_wr),
        .hist_area  (hist_area),
        .req_wr     (acc_wr),
        .req_area   (acc_area),
        .need_gap   (need_gap),
        .gap_cycles (gap_cycles)
    );

    gap_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_gap     (acc_req && need_gap),
        .load_cycles (gap_cycles),
        .accept      (accept),
        .idle_now    (idle_now),
        .gate_open   (gate_open)
    );

    assert_first_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !hist_valid) |-> acc_rdy);
    assert_same_area_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && hist_valid && !hist_wr && !acc_wr && acc_area == hist_area) |-> acc_rdy);
    assert_write_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && hist_valid && hist_wr && acc_wr) |-> !idle_busy);
    assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_busy |=> ($stable(hist_area) && $stable(hist_wr)));
endmodule

// File: tb/bus_idle_gap_bench.sv
module bus_idle_gap_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_wr = 1'b0;
    logic [2:0]  acc_area = '0;
    logic        acc_rdy, idle_busy;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_P/2) clk = ~clk;

    bus_idle_gap u_bus_idle_gap (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_area(acc_area), .acc_rdy(acc_rdy), .idle_busy(idle_busy),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata)
    );

    function automatic logic [11:0] mk_cfg(input logic [1:0] b, input logic [1:0] a,
                                           input logic [7:0] sel);
        return {b, a, sel};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one access, count stalled and idle cycles until it is accepted.
    task automatic do_access(input logic wr, input logic [2:0] area, input int exp,
                             input string tag, input bit mid = 1'b0,
                             input logic [11:0] mid_data = '0);
        int n_idle = 0;
        int n_stall = 0;
        bit done = 1'b0;
        @(negedge clk);
        acc_req = 1'b1;
        acc_wr = wr;
        acc_area = area;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (acc_rdy) begin
                done = 1'b1;
                break;
            end
            n_stall++;
            if (idle_busy) n_idle++;
            if (mid && n_stall == 1) begin
                cfg_we = 1'b1;
                cfg_wdata = mid_data;
            end
            @(negedge clk);
            cfg_we = 1'b0;
        end
        check(done, {tag, " accepted"}, done, 1);
        check(n_idle == exp, {tag, " idle cycles"}, n_idle, exp);
        check(n_stall == exp, {tag, " ready-low cycles"}, n_stall, exp);
        @(posedge clk);
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check(acc_rdy == 1'b1, "R9 reset ready", acc_rdy, 1);
        check(idle_busy == 1'b0, "R9 reset idle", idle_busy, 0);
    endtask

    task automatic t_first;
        do_access(1'b0, 3'd0, 0, "R1 first access");
    endtask

    task automatic t_defaults;
        do_access(1'b0, 3'd1, 4, "R9 R12 read-read diff default");
        do_access(1'b1, 3'd2, 4, "R9 read-write default");
        do_access(1'b0, 3'd2, 4, "R9 write-read default");
    endtask

    task automatic t_same_area;
        do_access(1'b0, 3'd2, 0, "R2 read-read same area");
        do_access(1'b0, 3'd2, 0, "R2 read-read same area again");
    endtask

    task automatic t_write_write;
        do_access(1'b1, 3'd3, 4, "R3 read-write lead-in");
        do_access(1'b1, 3'd4, 0, "R5 write-write diff area");
        do_access(1'b1, 3'd4, 0, "R5 write-write same area");
    endtask

    task automatic t_seta;
        for (int c = 0; c < 4; c++) begin
            write_cfg(mk_cfg(2'b00, 2'(c), 8'h00));
            do_access(1'b0, 3'd5, c + 1, "R6 setting A");
            do_access(1'b0, 3'd6, c + 1, "R6 setting A read-read");
        end
    endtask

    task automatic t_setb;
        int bexp [4] = '{1, 2, 4, 4};
        for (int c = 0; c < 4; c++) begin
            write_cfg(mk_cfg(2'(c), 2'b00, 8'hFF));
            do_access(1'b0, 3'd5, bexp[c], "R7 setting B");
            do_access(1'b0, 3'd6, bexp[c], "R7 setting B read-read");
        end
    endtask

    task automatic t_prev_sel;
        write_cfg(mk_cfg(2'b01, 2'b00, 8'b0000_0100));
        do_access(1'b0, 3'd2, 1, "R8 prev area A, upcoming B");
        do_access(1'b0, 3'd3, 2, "R8 prev area B, upcoming A");
    endtask

    task automatic t_read_write;
        do_access(1'b0, 3'd2, 1, "R3 lead-in read");
        do_access(1'b1, 3'd3, 2, "R3 read-write uses prev area B");
    endtask

    task automatic t_write_read;
        write_cfg(mk_cfg(2'b00, 2'b10, 8'hFF));
        do_access(1'b0, 3'd3, 3, "R4 write-read ignores select");
    endtask

    task automatic t_mid_write;
        write_cfg(mk_cfg(2'b00, 2'b11, 8'h00));
        do_access(1'b1, 3'd1, 4, "R11 gap unchanged by mid write", 1'b1,
                  mk_cfg(2'b00, 2'b00, 8'h00));
        do_access(1'b0, 3'd1, 1, "R11 new setting on next transition");
    endtask

    initial begin
        #(CLK_P * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first();
        t_defaults();
        t_same_area();
        t_write_write();
        t_seta();
        t_setb();
        t_prev_sel();
        t_read_write();
        t_write_read();
        t_mid_write();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule